// File: doc/BRIEF.md
# Serial Transmit Queue with Empty-Interrupt Holdoff

This block is the sending half of a classic byte-oriented serial port. A processor-side write strobe pushes bytes into a 16-entry queue. A serializer pulls each byte out and sends it on a single output line as a frame of one low start bit, eight data bits and one high stop bit. One bit is sent per baud tick. The baud tick is a single-cycle enable that comes from outside the block. The line rests high. A `full` flag tells the writer when further bytes would be dropped.

An interrupt line tells software when the queue has run dry, and the interrupt enable input masks it. This line has one special rule, which prevents a spurious second request while software is still refilling the queue. Suppose the queue drains after it only ever held a single byte. In that case the interrupt is held back for one character time, which is ten baud ticks. Suppose instead the queue held two or more bytes at the same moment during the burst. In that case the interrupt rises in the cycle the queue empties, and the holdoff is armed again for the next burst.

Top module: `txq_uart`

## Requirements
- R1: The queue stores up to 16 bytes. `full` is high exactly while 16 bytes are stored. A write strobe while `full` is high is dropped and leaves the stored count at 16.
- R2: When the serializer is idle and the queue is not empty, the head byte is removed on the next clock edge. `txd` goes low (start bit) in that same cycle, without waiting for a baud tick.
- R3: A frame on `txd` is a 0 start bit, then data bit 0 through data bit 7 (least significant first), then a 1 stop bit. Each bit stays on the line until the next baud tick. `txd` is 1 whenever no frame is in progress.
- R4: While a frame is in progress, the next byte is removed only on the baud tick that ends the stop bit. If a byte is waiting, its start bit follows immediately, so frames are sent back to back.
- R5: `full` falls in the cycle after a byte is removed from a full queue.
- R6: A write strobe and a removal in the same cycle are both performed, and the stored count does not change.
- R7: `irq` is high only when `irq_en` is 1, the queue is empty, and no holdoff is running. With `irq_en` at 0, `irq` is 0.
- R8: A write into an empty queue drops `irq` in the following cycle.
- R9: If the queue empties and it has not held two bytes at once since the last empty event, `irq` stays low for 10 baud ticks after the empty event. A write during that window cancels the window.
- R10: If the queue held two or more bytes at the same time, `irq` rises in the cycle the queue empties, with no holdoff.
- R11: After an empty event that had no holdoff, the holdoff is armed again, so the next single-byte burst is delayed as in R9.
- R12: After reset the queue is empty, `txd` is 1, `full` is 0, the holdoff is armed and not running, and `irq` follows `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Write strobe from the processor side |
| wr_data | input | 8 | Byte to enqueue |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| full | output | 1 | Queue holds 16 bytes; writes are dropped |
| txd | output | 1 | Serial output line, idles high |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
Queue counts, holdoff state and serializer state all change at the clock edge that samples the strobe or tick. As a result, `full` and `txd` are due one edge after the write, removal or tick that causes them. `irq` is also due one edge after its cause, but it additionally follows `irq_en` within the same cycle. The bench updates a behavioural reference at each rising edge using the inputs that were stable across that edge. It compares all three outputs shortly after each falling edge, when both the design's registers and the bench's drives have settled. Directed checks count baud ticks from the write that starts a burst, so they land either well inside a holdoff window or well past its end.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [0:0] {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    localparam int unsigned TXQ_BYTE_W = 8;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          s_d, s_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    assign full    = (s_q.cnt == FULL_CNT);
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push_req && !full;
    assign dout    = mem_q[s_q.rptr];
    assign count   = s_q.cnt;

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        if (push_ok) begin
            mem_d[s_q.wptr] = din;
            s_d.wptr = (s_q.wptr == LAST_IDX) ? '0 : s_q.wptr + AW'(1);
        end
        if (pop) begin
            s_d.rptr = (s_q.rptr == LAST_IDX) ? '0 : s_q.rptr + AW'(1);
        end
        case ({push_ok, pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
        mem_q <= mem_d;
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> (s_q.cnt == FULL_CNT));
    p_count_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop) |=> $stable(s_q.cnt));
    p_full_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop) |=> !full);
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
    import txq_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned FW = DW + 2,
    localparam int unsigned BW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          have_data,
    input  logic [DW-1:0] din,
    output logic          pop,
    output logic          txd
);
    localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

    typedef struct packed {
        sh_state_e     st;
        logic [FW-1:0] frame;
        logic [BW-1:0] bitcnt;
    } sh_t;

    sh_t s_d, s_q;
    logic stop_done;

    assign stop_done = (s_q.st == SH_BUSY) && baud_tick && (s_q.bitcnt == LAST_BIT);
    assign pop       = have_data && ((s_q.st == SH_IDLE) || stop_done);
    assign txd       = (s_q.st == SH_BUSY) ? s_q.frame[0] : 1'b1;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.st     = SH_BUSY;
            s_d.frame  = {1'b1, din, 1'b0};
            s_d.bitcnt = '0;
        end else if (stop_done) begin
            s_d.st = SH_IDLE;
        end else if ((s_q.st == SH_BUSY) && baud_tick) begin
            s_d.frame  = {1'b1, s_q.frame[FW-1:1]};
            s_d.bitcnt = s_q.bitcnt + BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SH_IDLE, frame: '1, bitcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (s_q.st == SH_IDLE)) |=> (txd == 1'b0));
    p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SH_BUSY) && (s_q.bitcnt == LAST_BIT)) |-> txd);
    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SH_BUSY) && !baud_tick) |=> $stable(txd));
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
    parameter int unsigned CW         = 5,
    parameter int unsigned CHAR_TICKS = 10,
    localparam int unsigned TW        = $clog2(CHAR_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic [CW-1:0] count,
    input  logic          push,
    input  logic          pop,
    input  logic          irq_en,
    output logic          irq
);
    localparam logic [TW-1:0] TICK_LAST = TW'(CHAR_TICKS - 1);

    typedef struct packed {
        logic          armed;
        logic          hold;
        logic [TW-1:0] tcnt;
    } ho_t;

    ho_t  s_d, s_q;
    logic drain_evt;

    assign drain_evt = pop && !push && (count == CW'(1));
    assign irq       = irq_en && (count == '0) && !s_q.hold;

    always_comb begin
        s_d = s_q;
        if (drain_evt && s_q.armed) begin
            s_d.hold = 1'b1;
            s_d.tcnt = '0;
        end else if (push) begin
            s_d.hold = 1'b0;
        end else if (s_q.hold && baud_tick) begin
            if (s_q.tcnt == TICK_LAST) begin
                s_d.hold = 1'b0;
            end else begin
                s_d.tcnt = s_q.tcnt + TW'(1);
            end
        end

        if (count >= CW'(2)) begin
            s_d.armed = 1'b0;
        end else if (drain_evt) begin
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{armed: 1'b1, hold: 1'b0, tcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    p_hold_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> (count == '0));
    p_first_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && push) |=> !irq);
    p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CW'(2)) |=> !s_q.armed);
    p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_evt |=> s_q.armed);
endmodule

// File: rtl/txq_uart.sv
module txq_uart #(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned DW         = txq_pkg::TXQ_BYTE_W,
    parameter int unsigned CHAR_TICKS = DW + 2,
    localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_en,
    output logic          full,
    output logic          txd,
    output logic          irq
);
    logic [DW-1:0] head;
    logic [CW-1:0] count;
    logic          push_ok;
    logic          empty;
    logic          pop;

    txq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .din      (wr_data),
        .pop      (pop),
        .dout     (head),
        .count    (count),
        .push_ok  (push_ok),
        .full     (full),
        .empty    (empty)
    );

    txq_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .have_data (!empty),
        .din       (head),
        .pop       (pop),
        .txd       (txd)
    );

    txq_irq #(.CW(CW), .CHAR_TICKS(CHAR_TICKS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .count     (count),
        .push      (push_ok),
        .pop       (pop),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/txq_uart_test.sv
module txq_uart_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en = 1'b1;
    logic       full, txd, irq;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    txq_uart uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .full(full), .txd(txd), .irq(irq)
    );

    // Behavioural reference
    byte unsigned q[$];
    bit m_busy, m_armed, m_hold;
    int m_cnt, m_tcnt;
    int unsigned m_frame;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_cnt = 0; m_frame = 0;
            m_armed = 1; m_hold = 0; m_tcnt = 0;
        end else begin
            int sz;
            bit do_pop, do_push, drain;
            sz = q.size();
            do_push = wr_en && (sz < 16);
            do_pop = (sz > 0) && (!m_busy || (baud_tick && m_cnt == 9));
            drain = do_pop && !do_push && (sz == 1);
            if (drain && m_armed) begin
                m_hold = 1; m_tcnt = 0;
            end else if (do_push) begin
                m_hold = 0;
            end else if (m_hold && baud_tick) begin
                if (m_tcnt == 9) m_hold = 0;
                else m_tcnt++;
            end
            if (sz >= 2) m_armed = 0;
            else if (drain) m_armed = 1;
            if (do_pop) begin
                m_frame = {22'd0, 1'b1, q.pop_front(), 1'b0};
                m_busy = 1; m_cnt = 0;
            end else if (m_busy && baud_tick) begin
                if (m_cnt == 9) m_busy = 0;
                else begin
                    m_frame = (m_frame >> 1) | 32'h200;
                    m_cnt++;
                end
            end
            if (do_push) q.push_back(wr_data);
        end
        started = 1;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (started && !done) begin
            chk("R1 R5 R6 full", full, q.size() == 16);
            chk("R2 R3 R4 txd", txd, m_busy ? m_frame[0] : 1'b1);
            chk("R7 R8 R9 R10 R11 irq", irq, irq_en && q.size() == 0 && !m_hold);
        end
    end

    // Baud tick every 3 clocks
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 txd idle", txd, 1'b1);
        chk("R12 full low", full, 1'b0);
        chk("R12 irq follows enable", irq, 1'b1);

        // Single byte: holdoff
        wr(8'hA5);
        #1;
        chk("R8 irq drops after first write", irq, 1'b0);
        wait_ticks(5);
        chk("R9 irq held off mid-window", irq, 1'b0);
        wait_ticks(7);
        chk("R9 irq after window", irq, 1'b1);
        wait_ticks(20);

        // Three bytes: two held at once, no holdoff
        wr(8'h3C); wr(8'hC3); wr(8'h0F);
        wait_ticks(22);
        chk("R10 irq immediate after multi-byte drain", irq, 1'b1);
        wait_ticks(20);

        // Re-armed single byte
        wr(8'h81);
        wait_ticks(5);
        chk("R11 holdoff re-armed", irq, 1'b0);
        wait_ticks(20);

        // Enable masked
        irq_en = 1'b0;
        #1;
        chk("R7 irq masked", irq, 1'b0);
        wait_ticks(15);
        chk("R7 irq masked idle", irq, 1'b0);
        irq_en = 1'b1;

        // Overfill
        @(negedge clk);
        wr_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wr_data = 8'(i * 37 + 5);
            @(negedge clk);
        end
        wr_en = 1'b0;
        #1;
        chk("R1 full after overfill", full, 1'b1);

        // Random traffic while draining
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 9) == 0);
            wr_data = 8'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        wait_ticks(400);
        chk("R3 line idle after drain", txd, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule